// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This controller sits between a processor and an on-chip flash array and turns self-programming requests into flash control pulses. Software first writes a command code into an 8-bit control/status register, which arms a short acceptance window. It then issues a program strobe together with a page address, a word address, a data word and a region select. If the strobe lands inside the window, the controller launches one of four actions: erase a page, write a page from the temporary buffer, load one word into that buffer, or re-enable reads of the read-while-write region.

Erase and write take a programmable number of clock cycles, counted here in place of the real cell timing. While one runs, the controller does one of two things, depending on the target region. It either blocks reads of the read-while-write region and leaves the CPU running, or it halts the CPU. A sticky busy bit records that the read-while-write region was programmed, and it stays set until software clears it with the re-enable command. A level interrupt is raised for as long as the interrupt is enabled and no command is armed or running.

Top module: `selfprog_ctrl`

## Requirements
- R1: A register write decodes bits[6:0] as follows: 0000011 is page erase, 0000101 is page write, 0000001 is buffer word load, and 0010001 is read re-enable. Bit 7 is stored as the interrupt enable. Any other value in bits[6:0] arms nothing. In the read value, bit 7 is the interrupt enable, bit 6 is the sticky busy flag, and bits[5:0] show the armed or running command code (bit 0 is the enable bit).
- R2: A program strobe is accepted when it is sampled on any of the four clock edges after the register write edge. A strobe sampled on the write edge itself, or five or more edges later, is discarded. Once four edges pass without a strobe, the enable bit clears.
- R3: An accepted load gives `buf_load` high for exactly one cycle after the strobe edge, with `buf_word` and `buf_data` carrying the strobe's word address and data. The enable bit clears at that same edge.
- R4: An accepted erase or write gives a one-cycle `fl_erase_go` or `fl_write_go` pulse, with `fl_page` carrying the page address. No buffer load occurs, and the word and data inputs have no effect.
- R5: While an erase or write runs on a read-while-write target (`region_nrww`=0), `rww_rd_block` is high and `cpu_halt` is low. On a no-read-while-write target, `cpu_halt` is high and `rww_rd_block` is low.
- R6: The enable bit and the active indication stay high for OP_CYCLES cycles after the strobe edge, then both clear.
- R7: Busy flag bit 6 rises when an erase or write to the read-while-write region starts. It stays set after completion until a re-enable command executes, which clears it and pulses `buf_clear` for one cycle.
- R8: `irq` is high whenever interrupt enable is set and the enable bit is clear, and stays high until one of those changes.
- R9: Completion of a page write pulses `buf_clear` for one cycle. Completion of a page erase does not.
- R10: Register writes issued while an erase or write runs are ignored entirely, including the interrupt enable bit, so a later strobe launches nothing.
- R11: After reset all command bits, the interrupt enable, the busy flag, the window and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control/status register read value |
| prog_stb | input | 1 | Program strobe that executes the armed command |
| addr_page | input | PAGE_W | Page address of the operation |
| addr_word | input | WORD_W | Word address within the page (load only) |
| prog_data | input | DATA_W | Data word (load only) |
| region_nrww | input | 1 | 1 = target lies in the no-read-while-write region |
| fl_erase_go | output | 1 | One-cycle page erase launch |
| fl_write_go | output | 1 | One-cycle page write launch |
| fl_page | output | PAGE_W | Latched page address for the array |
| buf_load | output | 1 | One-cycle temporary buffer write |
| buf_word | output | WORD_W | Buffer word address |
| buf_data | output | DATA_W | Buffer data word |
| buf_clear | output | 1 | One-cycle temporary buffer erase |
| cpu_halt | output | 1 | Stall the CPU |
| rww_rd_block | output | 1 | Reads of the read-while-write region are blocked |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situations to reach are at the edges of the acceptance window. One is a strobe on the fourth edge versus the fifth. Another is a strobe in the very cycle of the register write, which must neither fire nor cancel the pending arm. Getting these right depends on counting every edge exactly. The bench drives inputs on falling edges and places the strobe a fixed number of falling edges after the write. This lets it hit edges one, four and five, as well as the same edge. Writes and strobes issued during a running erase are a second corner. They are reached by arming a new command partway through a no-read-while-write erase, then checking after completion that nothing was loaded and the interrupt enable did not change.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_ERASE = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_LOAD  = 3'd3,
    CMD_REEN  = 3'd4
  } sp_cmd_e;

  localparam int CSR_W    = 8;
  localparam int IE_BIT   = 7;
  localparam int BUSY_BIT = 6;
  localparam int FIELD_W  = 6;

  // Command field decode over bits[6:0]
  function automatic sp_cmd_e decode_cmd(input logic [6:0] f);
    case (f)
      7'b0000011: decode_cmd = CMD_ERASE;
      7'b0000101: decode_cmd = CMD_WRITE;
      7'b0000001: decode_cmd = CMD_LOAD;
      7'b0010001: decode_cmd = CMD_REEN;
      default:    decode_cmd = CMD_NONE;
    endcase
  endfunction

  // Read-back code for an armed or running command
  function automatic logic [FIELD_W-1:0] cmd_field(input sp_cmd_e c);
    case (c)
      CMD_ERASE: cmd_field = 6'b000011;
      CMD_WRITE: cmd_field = 6'b000101;
      CMD_LOAD:  cmd_field = 6'b000001;
      CMD_REEN:  cmd_field = 6'b010001;
      default:   cmd_field = 6'b000000;
    endcase
  endfunction

endpackage

// File: rtl/sp_arm_window.sv
module sp_arm_window
  import selfprog_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_ok,
  input  sp_cmd_e wr_cmd,
  input  logic    prog_stb,
  output logic    armed,
  output sp_cmd_e arm_cmd,
  output logic    fire
);

  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          rearm;
  logic [CW-1:0] win_cnt;

  assign rearm = wr_ok && (wr_cmd != CMD_NONE);
  assign fire  = armed && prog_stb && !rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      arm_cmd <= CMD_NONE;
      win_cnt <= '0;
    end else if (rearm) begin
      armed   <= 1'b1;
      arm_cmd <= wr_cmd;
      win_cnt <= '0;
    end else if (armed) begin
      if (prog_stb || (win_cnt == CW'(WIN - 1))) begin
        armed   <= 1'b0;
        arm_cmd <= CMD_NONE;
        win_cnt <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  // R2: an accepted strobe consumes the arm
  assert_fire_disarms_R2: assert property (@(posedge clk) disable iff (rst)
    fire |=> !armed);

  // R2: an armed command always names a real action
  assert_armed_has_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (arm_cmd != CMD_NONE));

endmodule

// File: rtl/sp_op_timer.sv
module sp_op_timer #(
  parameter int OP_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_nrww,
  input  logic start_write,
  output logic active,
  output logic nrww,
  output logic is_write,
  output logic done
);

  localparam int TW = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

  logic [TW-1:0] tmr;

  assign done = active && (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      nrww     <= 1'b0;
      is_write <= 1'b0;
      tmr      <= '0;
    end else if (start) begin
      active   <= 1'b1;
      nrww     <= start_nrww;
      is_write <= start_write;
      tmr      <= TW'(OP_CYCLES - 1);
    end else if (done) begin
      active   <= 1'b0;
      nrww     <= 1'b0;
      is_write <= 1'b0;
    end else if (active) begin
      tmr <= tmr - 1'b1;
    end
  end

  // R6: a start always produces an active operation
  assert_start_active_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> active);

  // R6: completion ends the operation
  assert_done_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !active);

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int PAGE_W    = 7,
  parameter int WORD_W    = 7,
  parameter int DATA_W    = 16,
  parameter int OP_CYCLES = 20,
  parameter int ARM_WIN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CSR_W-1:0]  cfg_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  input  logic              prog_stb,
  input  logic [PAGE_W-1:0] addr_page,
  input  logic [WORD_W-1:0] addr_word,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              region_nrww,
  output logic              fl_erase_go,
  output logic              fl_write_go,
  output logic [PAGE_W-1:0] fl_page,
  output logic              buf_load,
  output logic [WORD_W-1:0] buf_word,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_clear,
  output logic              cpu_halt,
  output logic              rww_rd_block,
  output logic              irq
);

  logic    wr_ok;
  sp_cmd_e wr_cmd;
  logic    armed;
  sp_cmd_e arm_cmd;
  logic    fire;
  logic    op_start;
  logic    op_active;
  logic    op_nrww;
  logic    op_is_write;
  logic    op_done;

  logic    ie_q;
  logic    rww_busy_q;
  logic    erase_go_q;
  logic    write_go_q;
  logic    load_q;
  logic    clear_q;
  logic [PAGE_W-1:0] page_q;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] data_q;
  logic [FIELD_W-1:0] field_rd;

  // Writes are only taken while no erase/write is running
  assign wr_ok    = cfg_we && !op_active;
  assign wr_cmd   = decode_cmd(cfg_wdata[6:0]);
  assign op_start = fire && ((arm_cmd == CMD_ERASE) || (arm_cmd == CMD_WRITE));

  sp_arm_window #(.WIN(ARM_WIN)) arm_i (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok),
    .wr_cmd   (wr_cmd),
    .prog_stb (prog_stb),
    .armed    (armed),
    .arm_cmd  (arm_cmd),
    .fire     (fire)
  );

  sp_op_timer #(.OP_CYCLES(OP_CYCLES)) tmr_i (
    .clk         (clk),
    .rst         (rst),
    .start       (op_start),
    .start_nrww  (region_nrww),
    .start_write (arm_cmd == CMD_WRITE),
    .active      (op_active),
    .nrww        (op_nrww),
    .is_write    (op_is_write),
    .done        (op_done)
  );

  // Interrupt enable
  always_ff @(posedge clk) begin
    if (rst)        ie_q <= 1'b0;
    else if (wr_ok) ie_q <= cfg_wdata[IE_BIT];
  end

  // Sticky busy flag for the read-while-write region
  always_ff @(posedge clk) begin
    if (rst)                                rww_busy_q <= 1'b0;
    else if (op_start && !region_nrww)      rww_busy_q <= 1'b1;
    else if (fire && (arm_cmd == CMD_REEN)) rww_busy_q <= 1'b0;
  end

  // Launch pulses and latched operands
  always_ff @(posedge clk) begin
    if (rst) begin
      erase_go_q <= 1'b0;
      write_go_q <= 1'b0;
      load_q     <= 1'b0;
      clear_q    <= 1'b0;
      page_q     <= '0;
      word_q     <= '0;
      data_q     <= '0;
    end else begin
      erase_go_q <= fire && (arm_cmd == CMD_ERASE);
      write_go_q <= fire && (arm_cmd == CMD_WRITE);
      load_q     <= fire && (arm_cmd == CMD_LOAD);
      clear_q    <= (op_done && op_is_write) || (fire && (arm_cmd == CMD_REEN));
      if (op_start) page_q <= addr_page;
      if (fire && (arm_cmd == CMD_LOAD)) begin
        word_q <= addr_word;
        data_q <= prog_data;
      end
    end
  end

  always_comb begin
    if (armed)          field_rd = cmd_field(arm_cmd);
    else if (op_active) field_rd = op_is_write ? cmd_field(CMD_WRITE) : cmd_field(CMD_ERASE);
    else                field_rd = '0;
  end

  assign csr_rdata    = {ie_q, rww_busy_q, field_rd};
  assign fl_erase_go  = erase_go_q;
  assign fl_write_go  = write_go_q;
  assign fl_page      = page_q;
  assign buf_load     = load_q;
  assign buf_word     = word_q;
  assign buf_data     = data_q;
  assign buf_clear    = clear_q;
  assign cpu_halt     = op_active && op_nrww;
  assign rww_rd_block = op_active && !op_nrww;
  assign irq          = ie_q && !armed && !op_active;

  // R10: arming and running never overlap
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(armed && op_active));

  // R5: the two stall styles are exclusive
  assert_halt_xor_block_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> !rww_rd_block);

  // R7: blocked reads imply the busy flag is raised
  assert_block_busy_R7: assert property (@(posedge clk) disable iff (rst)
    rww_rd_block |-> rww_busy_q);

  // R8: completion with interrupts enabled raises the request
  assert_done_irq_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(op_active) && ie_q) |-> irq);

  // R4: at most one launch pulse at a time
  assert_one_launch_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_go_q, write_go_q, load_q}));

  // R4: an array launch coincides with a running operation
  assert_go_active_R4: assert property (@(posedge clk) disable iff (rst)
    (erase_go_q || write_go_q) |-> op_active);

endmodule

// File: tb/selfprog_ctrl_tb_top.sv
module selfprog_ctrl_tb_top;

  localparam int PAGE_W = 7;
  localparam int WORD_W = 7;
  localparam int DATA_W = 16;
  localparam int OPC    = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        csr_rdata;
  logic              prog_stb = 1'b0;
  logic [PAGE_W-1:0] addr_page = '0;
  logic [WORD_W-1:0] addr_word = '0;
  logic [DATA_W-1:0] prog_data = '0;
  logic              region_nrww = 1'b0;
  logic              fl_erase_go, fl_write_go, buf_load, buf_clear;
  logic              cpu_halt, rww_rd_block, irq;
  logic [PAGE_W-1:0] fl_page;
  logic [WORD_W-1:0] buf_word;
  logic [DATA_W-1:0] buf_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  selfprog_ctrl #(
    .PAGE_W(PAGE_W), .WORD_W(WORD_W), .DATA_W(DATA_W),
    .OP_CYCLES(OPC), .ARM_WIN(4)
  ) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .csr_rdata(csr_rdata), .prog_stb(prog_stb), .addr_page(addr_page),
    .addr_word(addr_word), .prog_data(prog_data), .region_nrww(region_nrww),
    .fl_erase_go(fl_erase_go), .fl_write_go(fl_write_go), .fl_page(fl_page),
    .buf_load(buf_load), .buf_word(buf_word), .buf_data(buf_data),
    .buf_clear(buf_clear), .cpu_halt(cpu_halt), .rww_rd_block(rww_rd_block),
    .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // strobe sampled k edges after the write edge; returns at negedge after it
  task automatic strobe_after(input int k);
    repeat (k - 1) @(negedge clk);
    prog_stb = 1'b1;
    @(negedge clk); prog_stb = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11", "csr", 32'(csr_rdata), 0);
    chk("R11", "pulses", 32'({fl_erase_go, fl_write_go, buf_load, buf_clear}), 0);
    chk("R11", "stall", 32'({cpu_halt, rww_rd_block, irq}), 0);
  endtask

  task automatic t_load(input int k, input logic [WORD_W-1:0] w, input logic [DATA_W-1:0] d);
    addr_word = w; prog_data = d; addr_page = 7'h55;
    csr_write(8'h01);
    chk("R1", "armed code", 32'(csr_rdata[5:0]), 32'h01);
    strobe_after(k);
    chk("R3", "buf_load", 32'(buf_load), 1);
    chk("R3", "buf_word", 32'(buf_word), 32'(w));
    chk("R3", "buf_data", 32'(buf_data), 32'(d));
    chk("R3", "en cleared", 32'(csr_rdata[0]), 0);
    chk("R4", "no array go", 32'({fl_erase_go, fl_write_go}), 0);
    @(negedge clk);
    chk("R3", "load one cycle", 32'(buf_load), 0);
  endtask

  task automatic t_window_edges;
    csr_write(8'h01);
    repeat (3) @(negedge clk);
    chk("R2", "en before expiry", 32'(csr_rdata[0]), 1);
    @(negedge clk);
    chk("R2", "en expired", 32'(csr_rdata[0]), 0);
    prog_stb = 1'b1; @(negedge clk); prog_stb = 1'b0;
    chk("R2", "late strobe no load", 32'(buf_load), 0);
    // strobe on the write edge itself
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'h01; prog_stb = 1'b1;
    @(negedge clk); cfg_we = 1'b0; prog_stb = 1'b0;
    chk("R2", "same-edge strobe ignored", 32'(buf_load), 0);
    chk("R2", "still armed", 32'(csr_rdata[0]), 1);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_erase_rww;
    region_nrww = 1'b0; addr_page = 7'd5;
    csr_write(8'h03);
    strobe_after(2);
    chk("R4", "erase go", 32'(fl_erase_go), 1);
    chk("R4", "page", 32'(fl_page), 5);
    chk("R4", "no load", 32'(buf_load), 0);
    chk("R5", "rww block", 32'({rww_rd_block, cpu_halt}), 32'b10);
    chk("R7", "busy set", 32'(csr_rdata[6]), 1);
    repeat (OPC - 1) @(negedge clk);
    chk("R6", "en held", 32'(csr_rdata[0]), 1);
    chk("R5", "block held", 32'(rww_rd_block), 1);
    @(negedge clk);
    chk("R6", "en cleared", 32'(csr_rdata[0]), 0);
    chk("R5", "block released", 32'(rww_rd_block), 0);
    chk("R7", "busy sticky", 32'(csr_rdata[6]), 1);
    chk("R9", "no clear after erase", 32'(buf_clear), 0);
  endtask

  task automatic t_reenable;
    csr_write(8'h11);
    strobe_after(1);
    chk("R7", "busy cleared", 32'(csr_rdata[6]), 0);
    chk("R7", "reenable clears buffer", 32'(buf_clear), 1);
    @(negedge clk);
    chk("R7", "clear one cycle", 32'(buf_clear), 0);
  endtask

  task automatic t_write_nrww;
    region_nrww = 1'b1; addr_page = 7'd9;
    csr_write(8'h05);
    strobe_after(3);
    chk("R4", "write go", 32'(fl_write_go), 1);
    chk("R4", "page", 32'(fl_page), 9);
    chk("R5", "halt", 32'({cpu_halt, rww_rd_block}), 32'b10);
    chk("R7", "no busy for nrww", 32'(csr_rdata[6]), 0);
    chk("R1", "running code", 32'(csr_rdata[5:0]), 32'h05);
    repeat (OPC - 1) @(negedge clk);
    chk("R5", "halt held", 32'(cpu_halt), 1);
    chk("R9", "no early clear", 32'(buf_clear), 0);
    @(negedge clk);
    chk("R5", "halt released", 32'(cpu_halt), 0);
    chk("R9", "clear on write done", 32'(buf_clear), 1);
    @(negedge clk);
    chk("R9", "clear one cycle", 32'(buf_clear), 0);
  endtask

  task automatic t_busy_ignore;
    region_nrww = 1'b1;
    csr_write(8'h03);
    strobe_after(1);
    csr_write(8'h81);
    strobe_after(1);
    chk("R10", "no load during op", 32'(buf_load), 0);
    repeat (OPC) @(negedge clk);
    chk("R10", "not armed after op", 32'(csr_rdata[0]), 0);
    chk("R10", "ie unchanged", 32'({csr_rdata[7], irq}), 0);
  endtask

  task automatic t_noop;
    csr_write(8'h07);
    chk("R1", "invalid arms nothing", 32'(csr_rdata[5:0]), 0);
    strobe_after(1);
    chk("R1", "no pulses", 32'({fl_erase_go, fl_write_go, buf_load, buf_clear}), 0);
    csr_write(8'h41);
    chk("R1", "bit6 set is invalid", 32'(csr_rdata[0]), 0);
  endtask

  task automatic t_irq;
    csr_write(8'h80);
    chk("R8", "irq idle", 32'(irq), 1);
    @(negedge clk);
    chk("R8", "irq level", 32'(irq), 1);
    csr_write(8'h81);
    chk("R8", "irq low while armed", 32'(irq), 0);
    strobe_after(2);
    chk("R8", "irq after load", 32'(irq), 1);
    csr_write(8'h00);
    chk("R8", "irq disabled", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load(1, 7'h12, 16'hBEEF);
    t_load(4, 7'h7F, 16'h0A5C);
    t_window_edges();
    t_erase_rww();
    t_reenable();
    t_write_nrww();
    t_busy_ignore();
    t_noop();
    t_irq();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule